// File: doc/BRIEF.md
# Page ECC Status Scanner

Once a page read has finished, this block turns the per-sector ECC outcome bytes into a summary for the host. A parameterised sector count is latched when `start` is pulsed. The scanner then reads 32-bit status words through a simple indexed port: it drives `stat_idx`, and the surrounding logic returns the matching word on `stat_word` in the same cycle.

The scanner handles each sector that sits in a non-zero word. For each one it reports the outcome, which is clean, corrected or failed. For every corrected sector it raises a handshaked request to the correction engine. It also adds that sector's symbol-error count to a running total. The scan stops at the first sector that cannot be corrected. A one-cycle `done` pulse closes the scan, with the total and a fail bit.

Top module: `ecc_status_scanner`

## Requirements
- R1: While reset is held and after it is released, `done`, `corr_req` and `sec_valid` are low, and `total` and `fail` are zero.
- R2: The scan covers exactly max(1, min(n_sectors/4, MAX_SECTORS/4)) status words, at indices 0 upward. It never reports a sector whose index lies beyond the last of those words.
- R3: In a non-zero word, byte lane k (bits 8k+7..8k) belongs to sector word*4+k. Lanes are reported in the order 0, 1, 2, 3, with one `sec_valid` cycle each. `sec_outcome` is 00 when bits 1:0 are 0, 01 when they are 1, and 10 when they are 2 or 3. `sec_count` carries bits 6:2.
- R4: A status word equal to zero produces no sector report and costs exactly one cycle. A scan of all-zero words therefore shows `done` on the (words+1)-th rising edge after `start` is sampled.
- R5: Each corrected sector raises `corr_req` with its sector index and count. These stay stable until `corr_ack` is sampled high. No further sector is reported while the request is open.
- R6: `total` equals the sum of the bits 6:2 counts of every corrected sector reported in the scan.
- R7: The first sector with outcome 10 sets `fail` and ends the scan. No later sector is reported and no further correction request is raised.
- R8: `done` is high for exactly one cycle per scan. `total` and `fail` keep their values after it until the next accepted `start`.
- R9: A `start` pulse that arrives while a scan is in progress is ignored, and the running scan completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (accepted only when idle) |
| n_sectors | input | NSEC_W (5) | Sectors in the page |
| stat_idx | output | WIDX_W (2) | Index of the status word requested |
| stat_word | input | 32 | Status word at `stat_idx`, four sector bytes |
| sec_valid | output | 1 | Sector report valid |
| sec_index | output | SIDX_W (4) | Reported sector index |
| sec_outcome | output | 2 | 00 clean, 01 corrected, 10 failed |
| sec_count | output | 5 | Symbol-error count field of the sector |
| corr_req | output | 1 | Correction request to the engine |
| corr_sector | output | SIDX_W (4) | Sector to correct |
| corr_count | output | 5 | Symbol errors in that sector |
| corr_ack | input | 1 | Engine accepted the request |
| done | output | 1 | One-cycle end-of-scan pulse |
| fail | output | 1 | An uncorrectable sector ended the scan |
| total | output | TOTAL_W (9) | Sum of corrected symbol counts |

## Verification
The hardest case to reach from the ports is an abort in the middle of a word, right after open correction requests. Here the scanner must drop later lanes and later non-zero words, even though their bytes would raise requests. Directed pages place an uncorrectable byte between correctable ones, with a correctable word after it. The acknowledge delay is varied so that the abort follows handshakes of different lengths. A mid-scan `start` is issued while a request waits for a deliberately slow acknowledge. Randomised pages mix zero words, clean lanes, counts up to 24 and failures, to cover the remaining orderings.

// File: rtl/ecc_scan_pkg.sv
package ecc_scan_pkg;

    localparam int WORD_BITS    = 32;
    localparam int LANES        = 4;
    localparam int CNT_W        = 5;
    localparam int MAX_SYMBOLS  = 24;

    typedef enum logic [1:0] {
        OUT_CLEAN  = 2'b00,
        OUT_FIXED  = 2'b01,
        OUT_FAILED = 2'b10
    } outcome_e;

    typedef struct packed {
        outcome_e          outcome;
        logic [CNT_W-1:0]  count;
    } lane_info_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_LANE,
        S_WAIT,
        S_DONE
    } scan_state_e;

    function automatic lane_info_t decode_lane(input logic [7:0] b);
        lane_info_t r;
        unique case (b[1:0])
            2'd0:    r.outcome = OUT_CLEAN;
            2'd1:    r.outcome = OUT_FIXED;
            default: r.outcome = OUT_FAILED;
        endcase
        r.count = b[6:2];
        return r;
    endfunction

endpackage

// File: rtl/ecc_word_span.sv
module ecc_word_span
    import ecc_scan_pkg::*;
#(
    parameter int MAX_SECTORS = 16,
    parameter int NSEC_W      = $clog2(MAX_SECTORS + 1),
    parameter int NW_W        = 3
) (
    input  logic [NSEC_W-1:0] n_sectors,
    output logic [NW_W-1:0]   n_words
);
    localparam int MAX_WORDS = (MAX_SECTORS / LANES) < 1 ? 1 : (MAX_SECTORS / LANES);

    logic [NSEC_W-1:0] quot;

    always_comb begin
        quot = n_sectors >> 2;
        if (quot == '0)
            n_words = NW_W'(1);
        else if (int'(quot) > MAX_WORDS)
            n_words = NW_W'(MAX_WORDS);
        else
            n_words = NW_W'(quot);
    end
endmodule

// File: rtl/ecc_lane_decode.sv
module ecc_lane_decode
    import ecc_scan_pkg::*;
(
    input  logic [WORD_BITS-1:0] word,
    input  logic [1:0]           sel,
    output lane_info_t           info
);
    lane_info_t lanes [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lanes[k] = decode_lane(word[8*k +: 8]);
    end

    assign info = lanes[sel];
endmodule

// File: rtl/ecc_status_scanner.sv
module ecc_status_scanner
    import ecc_scan_pkg::*;
#(
    parameter int MAX_SECTORS = 16,
    localparam int MAX_WORDS  = (MAX_SECTORS / LANES) < 1 ? 1 : (MAX_SECTORS / LANES),
    localparam int WIDX_W     = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
    localparam int NW_W       = WIDX_W + 1,
    localparam int NSEC_W     = $clog2(MAX_SECTORS + 1),
    localparam int SIDX_W     = WIDX_W + 2,
    localparam int TOTAL_W    = $clog2(MAX_SYMBOLS * MAX_SECTORS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [NSEC_W-1:0]    n_sectors,
    output logic [WIDX_W-1:0]    stat_idx,
    input  logic [31:0]          stat_word,
    output logic                 sec_valid,
    output logic [SIDX_W-1:0]    sec_index,
    output logic [1:0]           sec_outcome,
    output logic [4:0]           sec_count,
    output logic                 corr_req,
    output logic [SIDX_W-1:0]    corr_sector,
    output logic [4:0]           corr_count,
    input  logic                 corr_ack,
    output logic                 done,
    output logic                 fail,
    output logic [TOTAL_W-1:0]   total
);
    scan_state_e        state;
    logic [WIDX_W-1:0]  widx;
    logic [1:0]         lane;
    logic [31:0]        wreg;
    logic [NW_W-1:0]    nwords_r;
    logic [NW_W-1:0]    nwords_in;
    logic [TOTAL_W-1:0] total_r;
    logic               fail_r;
    lane_info_t         info;

    ecc_word_span #(.MAX_SECTORS(MAX_SECTORS), .NSEC_W(NSEC_W), .NW_W(NW_W)) u_span (
        .n_sectors (n_sectors),
        .n_words   (nwords_in)
    );

    ecc_lane_decode u_dec (
        .word (wreg),
        .sel  (lane),
        .info (info)
    );

    // position bookkeeping after a sector is finished
    logic              last_word;
    scan_state_e       adv_state;
    logic [WIDX_W-1:0] adv_widx;
    logic [1:0]        adv_lane;

    assign last_word = ({1'b0, widx} + NW_W'(1)) == nwords_r;

    always_comb begin
        adv_widx  = widx;
        adv_lane  = lane + 2'd1;
        adv_state = S_LANE;
        if (lane == 2'd3) begin
            adv_lane = 2'd0;
            if (last_word) begin
                adv_state = S_DONE;
            end else begin
                adv_state = S_FETCH;
                adv_widx  = widx + WIDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            widx     <= '0;
            lane     <= '0;
            wreg     <= '0;
            nwords_r <= NW_W'(1);
            total_r  <= '0;
            fail_r   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    nwords_r <= nwords_in;
                    widx     <= '0;
                    lane     <= '0;
                    total_r  <= '0;
                    fail_r   <= 1'b0;
                    state    <= S_FETCH;
                end
                S_FETCH: begin
                    if (stat_word == '0) begin
                        if (last_word) state <= S_DONE;
                        else           widx  <= widx + WIDX_W'(1);
                    end else begin
                        wreg  <= stat_word;
                        lane  <= '0;
                        state <= S_LANE;
                    end
                end
                S_LANE: begin
                    unique case (info.outcome)
                        OUT_FIXED: begin
                            total_r <= total_r + TOTAL_W'(info.count);
                            state   <= S_WAIT;
                        end
                        OUT_FAILED: begin
                            fail_r <= 1'b1;
                            state  <= S_DONE;
                        end
                        default: begin
                            state <= adv_state;
                            widx  <= adv_widx;
                            lane  <= adv_lane;
                        end
                    endcase
                end
                S_WAIT: if (corr_ack) begin
                    state <= adv_state;
                    widx  <= adv_widx;
                    lane  <= adv_lane;
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign stat_idx    = widx;
    assign sec_valid   = (state == S_LANE);
    assign sec_index   = {widx, lane};
    assign sec_outcome = info.outcome;
    assign sec_count   = info.count;
    assign corr_req    = (state == S_WAIT);
    assign corr_sector = {widx, lane};
    assign corr_count  = info.count;
    assign done        = (state == S_DONE);
    assign fail        = fail_r;
    assign total       = total_r;

    // R5: an open request keeps its payload until acknowledged
    a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
        (corr_req && !corr_ack) |=> (corr_req && $stable(corr_sector) && $stable(corr_count)));

    // R7: after an abort nothing more is reported or requested
    a_r7_quiet_after_fail: assert property (@(posedge clk) disable iff (rst)
        (fail_r && state != S_IDLE) |-> (!corr_req && !sec_valid));

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: the running total never shrinks inside a scan
    a_r6_total_grows: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE) |=> (total_r >= $past(total_r)));

    // R2: only words inside the latched span are fetched
    a_r2_idx_range: assert property (@(posedge clk) disable iff (rst)
        (state == S_FETCH) |-> ({1'b0, stat_idx} < nwords_r));

    // R4: a zero word yields no sector report
    a_r4_zero_skip: assert property (@(posedge clk) disable iff (rst)
        (state == S_FETCH && stat_word == '0) |=> !sec_valid);
endmodule

// File: tb/ecc_status_scanner_test.sv
`timescale 1ns/1ps
module ecc_status_scanner_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  n_sectors = '0;
    logic [1:0]  stat_idx;
    logic [31:0] stat_word;
    logic        sec_valid;
    logic [3:0]  sec_index;
    logic [1:0]  sec_outcome;
    logic [4:0]  sec_count;
    logic        corr_req;
    logic [3:0]  corr_sector;
    logic [4:0]  corr_count;
    logic        corr_ack = 1'b0;
    logic        done;
    logic        fail;
    logic [8:0]  total;

    logic [31:0] smem [0:3];
    assign stat_word = smem[stat_idx];

    ecc_status_scanner uut (
        .clk(clk), .rst(rst), .start(start), .n_sectors(n_sectors),
        .stat_idx(stat_idx), .stat_word(stat_word),
        .sec_valid(sec_valid), .sec_index(sec_index), .sec_outcome(sec_outcome),
        .sec_count(sec_count), .corr_req(corr_req), .corr_sector(corr_sector),
        .corr_count(corr_count), .corr_ack(corr_ack), .done(done),
        .fail(fail), .total(total)
    );

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    int ack_delay = 0;
    int wcnt = 0;

    int rep_idx[$], rep_out[$], rep_cnt[$];
    int req_idx[$], req_cnt[$];
    int exp_total, exp_fail;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // cycle-by-cycle monitor against the expected event queues
    always @(negedge clk) begin
        if (rst) begin
            corr_ack = 1'b0;
            wcnt = 0;
        end else begin
            if (corr_ack) begin
                corr_ack = 1'b0;
                wcnt = 0;
                if (req_idx.size() > 0) begin
                    void'(req_idx.pop_front());
                    void'(req_cnt.pop_front());
                end
            end else if (corr_req) begin
                if (req_idx.size() == 0) begin
                    chk("R7 request after abort or unexpected", 1, 0);
                end else begin
                    chk("R5 corr_sector", int'(corr_sector), req_idx[0]);
                    chk("R5 corr_count", int'(corr_count), req_cnt[0]);
                end
                if (wcnt >= ack_delay) corr_ack = 1'b1;
                else wcnt++;
            end
            if (sec_valid) begin
                chk("R5 no report during request", int'(corr_req), 0);
                if (rep_idx.size() == 0) begin
                    chk("R7 report after abort or unexpected", 1, 0);
                end else begin
                    chk("R3 sec_index", int'(sec_index), rep_idx.pop_front());
                    chk("R3 sec_outcome", int'(sec_outcome), rep_out.pop_front());
                    chk("R3 sec_count", int'(sec_count), rep_cnt.pop_front());
                end
            end
        end
    end

    task automatic build_expect(input int n);
        int nw;
        bit stop;
        nw = n / 4;
        if (nw < 1) nw = 1;
        if (nw > 4) nw = 4;
        exp_total = 0;
        exp_fail = 0;
        stop = 0;
        rep_idx.delete(); rep_out.delete(); rep_cnt.delete();
        req_idx.delete(); req_cnt.delete();
        for (int w = 0; w < nw && !stop; w++) begin
            if (smem[w] != 32'h0) begin
                for (int k = 0; k < 4 && !stop; k++) begin
                    int b, st, c;
                    b  = (smem[w] >> (8 * k)) & 'hff;
                    st = b & 3;
                    c  = (b >> 2) & 'h1f;
                    rep_idx.push_back(w * 4 + k);
                    rep_cnt.push_back(c);
                    if (st == 0) begin
                        rep_out.push_back(0);
                    end else if (st == 1) begin
                        rep_out.push_back(1);
                        req_idx.push_back(w * 4 + k);
                        req_cnt.push_back(c);
                        exp_total += c;
                    end else begin
                        rep_out.push_back(2);
                        exp_fail = 1;
                        stop = 1;
                    end
                end
            end
        end
    endtask

    task automatic run_case(input int n, input int delay, input bit mid_start, input int exp_edges);
        int edges;
        build_expect(n);
        ack_delay = delay;
        @(negedge clk);
        n_sectors = 5'(n);
        start = 1'b1;
        edges = 0;
        forever begin
            @(posedge clk); #2;
            edges++;
            if (edges == 1) start = 1'b0;
            if (mid_start && edges == 3) start = 1'b1;
            if (mid_start && edges == 4) start = 1'b0;
            if (done) break;
            if (edges > 3000) begin
                chk("R8 done never seen", 0, 1);
                break;
            end
        end
        chk("R6 total at done", int'(total), exp_total);
        chk("R7 fail at done", int'(fail), exp_fail);
        if (exp_edges >= 0) chk("R4 zero-word scan length", edges, exp_edges);
        @(posedge clk); #2;
        chk("R8 done one cycle", int'(done), 0);
        chk("R8 total held", int'(total), exp_total);
        chk("R8 fail held", int'(fail), exp_fail);
        chk("R2 all expected reports seen", rep_idx.size(), 0);
        chk("R5 all expected requests seen", req_idx.size(), 0);
        repeat (2) @(posedge clk);
    endtask

    function automatic logic [7:0] rand_byte();
        int r;
        r = $urandom % 8;
        if (r < 4) return 8'h00;
        if (r < 7) return {1'b0, 5'(1 + ($urandom % 24)), 2'b01};
        return {1'b0, 5'($urandom % 32), 2'(2 + ($urandom % 2))};
    endfunction

    initial begin
        for (int i = 0; i < 4; i++) smem[i] = 32'h0;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 done in reset", int'(done), 0);
        chk("R1 corr_req in reset", int'(corr_req), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #2;
        chk("R1 done after reset", int'(done), 0);
        chk("R1 corr_req after reset", int'(corr_req), 0);
        chk("R1 sec_valid after reset", int'(sec_valid), 0);
        chk("R1 total after reset", int'(total), 0);
        chk("R1 fail after reset", int'(fail), 0);

        // R4: all-zero 16-sector page, one cycle per word
        run_case(16, 0, 0, 5);
        // R2: zero sectors still scans one word
        run_case(0, 0, 0, 2);

        // R3 R6: single word, mixed lanes
        smem[0] = {8'h0D, 8'h00, 8'h05, 8'h00};
        run_case(4, 1, 0, -1);

        // R2: 2 sectors -> one word; word 1 must not be read
        smem[0] = {8'h00, 8'h00, 8'h61, 8'h09};
        smem[1] = 32'h0505_0505;
        run_case(2, 0, 0, -1);

        // R7: abort mid-word with later correctable word
        smem[0] = 32'h0;
        smem[1] = {8'h61, 8'h61, 8'h00, 8'h21};
        smem[2] = {8'h05, 8'h05, 8'h02, 8'h11};
        smem[3] = 32'h0505_0505;
        run_case(16, 2, 0, -1);

        // R7: immediate uncorrectable in lane 0 (code 3)
        smem[0] = {8'h05, 8'h05, 8'h05, 8'h03};
        run_case(8, 0, 0, -1);

        // R9: start during an open request is ignored
        smem[0] = {8'h00, 8'h00, 8'h00, 8'h0D};
        smem[1] = {8'h15, 8'h00, 8'h00, 8'h00};
        run_case(8, 6, 1, -1);

        // R6: maximum counts everywhere
        for (int i = 0; i < 4; i++) smem[i] = 32'h6161_6161;
        run_case(16, 0, 0, -1);

        // randomised pages
        for (int t = 0; t < 40; t++) begin
            for (int i = 0; i < 4; i++) begin
                if (($urandom % 4) == 0) smem[i] = 32'h0;
                else smem[i] = {rand_byte(), rand_byte(), rand_byte(), rand_byte()};
            end
            run_case(4 * (1 + ($urandom % 4)), $urandom % 4, 0, -1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule